// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block collects interrupt requests from 32 lines, raised either by hardware request pulses or by software commands, and tells the CPU which one to service next. Each line has an 8-bit urgency value, an enable bit, a pre-mask bit and a pending bit. A global lock hides every request from the CPU without discarding it. A `cpu_wake` pulse tells a sleeping CPU that something needs attention.

The CPU takes the offered line with an `ack` strobe and leaves a handler with an `eoi` strobe. The controller keeps the urgency of every handler in progress in a hardware stack. Only a request strictly more urgent than the handler now running is offered, so handlers nest without software bookkeeping.

The stack is run by a three-state machine. `LVL_IDLE` means no handler is running and the running level is 256. `LVL_NESTED` means between one and DEPTH-1 handlers are stacked. `LVL_FULL` means all DEPTH entries are in use. The transitions are:

- `LVL_IDLE` to `LVL_NESTED` on an accepted acknowledge.
- `LVL_NESTED` to `LVL_FULL` on an acknowledge at depth DEPTH-1.
- `LVL_NESTED` to `LVL_IDLE` on a return at depth 1.
- `LVL_FULL` to `LVL_NESTED` on a return.

Any other acknowledge or return keeps the current state and moves the depth by one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Of the lines that are both pending and enabled, the offered line is the one with the numerically smallest urgency value (0 most urgent, 255 least). When urgency values are equal, the lowest line number wins.
- R2: After reset:
  - every line is disabled;
  - every urgency value is 255;
  - the pre-mask and pending bits are clear;
  - the lock is released;
  - `sel_valid`, `cpu_wake` and `stack_err` are 0.
- R3: The running level is 256 while no handler runs, and otherwise the urgency of the innermost handler. A line is offered only if its urgency value is strictly below the running level.
- R4: A raise of a line, by hardware or software, always sets its pre-mask bit. The raise sets the pending bit only if the line is enabled. Enabling a line whose pre-mask bit is set makes it pending at once. A disabled line is never offered.
- R5: While the lock is set, `sel_valid` is 0, but raises are still recorded. A lock-release command issued while locked with any pending bit set pulses `cpu_wake`.
- R6: A hardware raise pulses `cpu_wake` even on a disabled line, unless the lock is set. The `hard_wake` input pulses `cpu_wake` regardless of the lock.
- R7: An `ack` while `sel_valid` is 1 and the stack is not full does three things:
  - clears the pending and pre-mask bits of `sel_line`;
  - pushes that line's urgency, which becomes the running level;
  - forces `sel_valid` to 0 in the following cycle.

  An `ack` in the same cycle as `eoi` is ignored.
- R8: An `eoi` pops the stack and restores the previous running level, and forces `sel_valid` to 0 in the following cycle. An `eoi` with an empty stack changes nothing.
- R9: The clear-all command behaves according to `cmd_data[0]`:
  - with 1, it clears every pending and pre-mask bit;
  - with 0, it clears every pending bit but only the pre-mask bits of enabled lines.

  The single-line clear command clears both bits of `cmd_line`.
- R10: A software set-pending command pulses `cpu_wake` when all of the following hold: the line is enabled, the lock is clear, and the line's urgency value is below the running level.
- R11: An acknowledge while all DEPTH (8) stack entries are in use changes no state except that it sets `stack_err`, which stays set until reset.
- R12: `cmd_op` encodings, acted on only while `cmd_valid` is 1:
  - 0: no effect;
  - 1: write `cmd_data` as the urgency of `cmd_line`;
  - 2: enable `cmd_line`;
  - 3: disable `cmd_line`;
  - 4: software set-pending of `cmd_line`;
  - 5: single-line clear;
  - 6: set the lock to `cmd_data[0]`;
  - 7: clear-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 32 | One-cycle hardware raise per line |
| hard_wake | input | 1 | Wake pulse that ignores the lock |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_line | input | 5 | Line addressed by the command |
| cmd_data | input | 8 | Urgency value or lock/clear flag |
| ack | input | 1 | CPU takes the offered line |
| eoi | input | 1 | CPU returns from the innermost handler |
| sel_valid | output | 1 | An offered line exists |
| sel_line | output | 5 | Offered line number |
| cpu_wake | output | 1 | One-cycle wake pulse |
| stack_err | output | 1 | Sticky nesting overflow flag |

## Verification
A command, raise or strobe takes effect on the register state at the first rising edge that samples it. `cpu_wake` and `stack_err` are therefore due right after that edge. The offered line is recomputed from the new state at the following edge, so `sel_valid` and `sel_line` are due one clock later. The bench drives inputs and samples outputs on falling edges. It reads wake and error results at the falling edge that ends the stimulus, and reads the selection only after one extra falling edge. Expected winners in the urgency sweeps come from an arithmetic model in the bench of urgency values and pending bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PRIO   = 3'd1,
        OP_EN     = 3'd2,
        OP_DIS    = 3'd3,
        OP_SETP   = 3'd4,
        OP_CLRP   = 3'd5,
        OP_LOCK   = 3'd6,
        OP_CLRALL = 3'd7
    } pic_op_e;

    typedef enum logic [1:0] {
        LVL_IDLE   = 2'd0,
        LVL_NESTED = 2'd1,
        LVL_FULL   = 2'd2
    } lvl_state_e;
endpackage

// File: rtl/pic_line_regs.sv
module pic_line_regs
    import pic_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 8,
    localparam int LW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    hw_req,
    input  logic            hard_wake,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [LW-1:0]   cmd_line,
    input  logic [PW-1:0]   cmd_data,
    input  logic            ack_fire,
    input  logic [LW-1:0]   ack_line,
    input  logic [PW:0]     running,
    output logic [N-1:0]    enable_q,
    output logic [N-1:0]    pending_q,
    output logic [N*PW-1:0] prio_flat,
    output logic            lock_q,
    output logic            cpu_wake_q
);
    pic_op_e         op;
    logic [N-1:0]    oh, ack_oh, premask_q;
    logic [N-1:0]    en_n, pm_n, pend_n, clr_p, clr_m, raise;
    logic [PW-1:0]   prio_q [N];
    logic            sw_preempt, unlock_evt, hw_evt;

    assign op     = pic_op_e'(cmd_op);
    assign oh     = N'(1) << cmd_line;
    assign ack_oh = N'(1) << ack_line;

    // per-line urgency registers (R12 op 1), reset to least urgent (R2)
    for (genvar g = 0; g < N; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[g] <= '1;
            else if (cmd_valid && op == OP_PRIO && cmd_line == LW'(g))
                prio_q[g] <= cmd_data;
        end
        assign prio_flat[g*PW +: PW] = prio_q[g];
    end

    always_comb begin
        en_n  = enable_q;
        clr_p = '0;
        clr_m = '0;
        raise = hw_req;
        if (cmd_valid) begin
            unique case (op)
                OP_EN:     en_n = enable_q | oh;
                OP_DIS:    en_n = enable_q & ~oh;
                OP_SETP:   raise = hw_req | oh;
                OP_CLRP:   begin clr_p = oh; clr_m = oh; end
                OP_CLRALL: begin
                    clr_p = '1;
                    clr_m = cmd_data[0] ? '1 : enable_q;
                end
                default:   ;
            endcase
        end
        if (ack_fire) begin
            clr_p = clr_p | ack_oh;
            clr_m = clr_m | ack_oh;
        end
        pm_n   = (premask_q & ~clr_m) | raise;
        pend_n = (pending_q & ~clr_p) | (raise & en_n);
        if (cmd_valid && op == OP_EN)
            pend_n = pend_n | (oh & premask_q);
    end

    assign sw_preempt = cmd_valid && op == OP_SETP && enable_q[cmd_line] &&
                        !lock_q && ({1'b0, prio_q[cmd_line]} < running);
    assign unlock_evt = cmd_valid && op == OP_LOCK && !cmd_data[0] &&
                        lock_q && (|pending_q);
    assign hw_evt     = (|hw_req) && !lock_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q   <= '0;
            premask_q  <= '0;
            pending_q  <= '0;
            lock_q     <= 1'b0;
            cpu_wake_q <= 1'b0;
        end else begin
            enable_q   <= en_n;
            premask_q  <= pm_n;
            pending_q  <= pend_n;
            if (cmd_valid && op == OP_LOCK)
                lock_q <= cmd_data[0];
            cpu_wake_q <= hw_evt | hard_wake | unlock_evt | sw_preempt;
        end
    end
endmodule

// File: rtl/pic_select.sv
module pic_select #(
    parameter int N  = 32,
    parameter int PW = 8,
    localparam int LW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pending,
    input  logic [N-1:0]    enable,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [PW:0]     running,
    input  logic            lock,
    input  logic            block,
    output logic            sel_valid_q,
    output logic [LW-1:0]   sel_line_q
);
    logic          best_v;
    logic [PW:0]   best_p;
    logic [LW-1:0] best_l;

    // strict compare seeded with the running level: beats level and keeps lowest index on ties
    always_comb begin
        best_v = 1'b0;
        best_p = running;
        best_l = '0;
        for (int i = 0; i < N; i++) begin
            if (pending[i] && enable[i] && ({1'b0, prio_flat[i*PW +: PW]} < best_p)) begin
                best_v = 1'b1;
                best_p = {1'b0, prio_flat[i*PW +: PW]};
                best_l = LW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_line_q  <= '0;
        end else begin
            sel_valid_q <= best_v && !lock && !block;
            sel_line_q  <= best_l;
        end
    end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
    import pic_pkg::*;
#(
    parameter int PW    = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [PW-1:0] push_prio,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          full,
    output logic [PW:0]   running,
    output logic          stack_err
);
    lvl_state_e    state_q, state_n;
    logic [DW-1:0] depth_q, depth_n;
    logic [PW-1:0] stk [DEPTH];
    logic [DW-1:0] top_idx;

    assign top_idx = depth_q - DW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LVL_IDLE;
            depth_q   <= '0;
            stack_err <= 1'b0;
        end else begin
            state_q <= state_n;
            depth_q <= depth_n;
            if (push_req && state_q == LVL_FULL)
                stack_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            stk[depth_q[AW-1:0]] <= push_prio;
    end

    // next state
    always_comb begin
        state_n = state_q;
        depth_n = depth_q;
        unique case (state_q)
            LVL_IDLE: begin
                if (push_req) begin
                    state_n = LVL_NESTED;
                    depth_n = DW'(1);
                end
            end
            LVL_NESTED: begin
                if (pop_req) begin
                    depth_n = depth_q - DW'(1);
                    state_n = (depth_q == DW'(1)) ? LVL_IDLE : LVL_NESTED;
                end else if (push_req) begin
                    depth_n = depth_q + DW'(1);
                    state_n = (depth_q == DW'(DEPTH - 1)) ? LVL_FULL : LVL_NESTED;
                end
            end
            LVL_FULL: begin
                if (pop_req) begin
                    depth_n = depth_q - DW'(1);
                    state_n = LVL_NESTED;
                end
            end
            default: begin
                state_n = LVL_IDLE;
                depth_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        push_ok = 1'b0;
        full    = 1'b0;
        running = {1'b1, {PW{1'b0}}};
        unique case (state_q)
            LVL_IDLE:   push_ok = push_req;
            LVL_NESTED: begin
                push_ok = push_req;
                running = {1'b0, stk[top_idx[AW-1:0]]};
            end
            LVL_FULL:   begin
                full    = 1'b1;
                running = {1'b0, stk[top_idx[AW-1:0]]};
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N     = 32,
    parameter int PW    = 8,
    parameter int DEPTH = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  hw_req,
    input  logic          hard_wake,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [LW-1:0] cmd_line,
    input  logic [PW-1:0] cmd_data,
    input  logic          ack,
    input  logic          eoi,
    output logic          sel_valid,
    output logic [LW-1:0] sel_line,
    output logic          cpu_wake,
    output logic          stack_err
);
    logic [N-1:0]    enable_q, pending_q;
    logic [N*PW-1:0] prio_flat;
    logic            lock_q, push_req, push_ok, lvl_full;
    logic [PW:0]     running;

    assign push_req = ack && sel_valid && !eoi;

    pic_line_regs #(.N(N), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hard_wake(hard_wake),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .cmd_data(cmd_data), .ack_fire(push_ok), .ack_line(sel_line),
        .running(running), .enable_q(enable_q), .pending_q(pending_q),
        .prio_flat(prio_flat), .lock_q(lock_q), .cpu_wake_q(cpu_wake)
    );

    pic_select #(.N(N), .PW(PW)) u_sel (
        .clk(clk), .rst_n(rst_n), .pending(pending_q), .enable(enable_q),
        .prio_flat(prio_flat), .running(running), .lock(lock_q),
        .block(ack | eoi), .sel_valid_q(sel_valid), .sel_line_q(sel_line)
    );

    pic_level_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_req(push_req),
        .push_prio(prio_flat[sel_line*PW +: PW]), .pop_req(eoi),
        .push_ok(push_ok), .full(lvl_full), .running(running),
        .stack_err(stack_err)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N = 32,
    localparam int LW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lock_q,
    input logic          sel_valid,
    input logic [LW-1:0] sel_line,
    input logic          hard_wake,
    input logic          cpu_wake,
    input logic          stack_err,
    input logic          ack,
    input logic          eoi,
    input logic          full,
    input logic [N-1:0]  pending,
    input logic [N-1:0]  hw_req,
    input logic          cmd_valid
);
    p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> !sel_valid);

    p_lock_no_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !hard_wake && !cmd_valid) |=> !cpu_wake);

    p_hard_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hard_wake |=> cpu_wake);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && sel_valid && !full && hw_req == '0 && !cmd_valid)
        |=> !pending[$past(sel_line)]);

    p_strobe_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || eoi) |=> !sel_valid);

    p_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && sel_valid && full) |=> stack_err);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .sel_valid(sel_valid),
    .sel_line(sel_line), .hard_wake(hard_wake), .cpu_wake(cpu_wake),
    .stack_err(stack_err), .ack(ack), .eoi(eoi), .full(lvl_full),
    .pending(pending_q), .hw_req(hw_req), .cmd_valid(cmd_valid)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_req = '0;
    logic        hard_wake = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_line = '0;
    logic [7:0]  cmd_data = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        sel_valid, cpu_wake, stack_err;
    logic [4:0]  sel_line;

    int checks = 0;
    int fails = 0;
    int prio_m [32];
    logic [31:0] pend_m;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hard_wake(hard_wake),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .cmd_data(cmd_data), .ack(ack), .eoi(eoi), .sel_valid(sel_valid),
        .sel_line(sel_line), .cpu_wake(cpu_wake), .stack_err(stack_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // offered line encoded as line+1, 0 meaning none
    task automatic check_sel(input string req, input int exp_code);
        check(req, sel_valid ? int'(sel_line) + 1 : 0, exp_code);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_cmd(input int op, input int line, input int data);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_line  = 5'(line);
        cmd_data  = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = '0;
    endtask

    task automatic pulse_hw(input int line);
        hw_req = 32'd1 << line;
        @(negedge clk);
        hw_req = '0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    function automatic int winner();
        int best = 256;
        int w = 0;
        for (int i = 0; i < 32; i++)
            if (pend_m[i] && prio_m[i] < best) begin
                best = prio_m[i];
                w = i + 1;
            end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R2 reset state
        check("R2 sel_valid", int'(sel_valid), 0);
        check("R2 cpu_wake", int'(cpu_wake), 0);
        check("R2 stack_err", int'(stack_err), 0);
        // R2: lines start disabled, so a software raise is not offered
        do_cmd(4, 0, 0);
        check("R2 wake on disabled", int'(cpu_wake), 0);
        settle();
        check_sel("R2 disabled not offered", 0);
        do_cmd(5, 0, 0);

        // R12 op 2: enable every line
        for (int i = 0; i < 32; i++) do_cmd(2, i, 0);

        // R3 line sweep: default urgency 255 beats idle level 256
        for (int i = 0; i < 32; i++) begin
            do_cmd(4, i, 0);
            check("R10 wake on set", int'(cpu_wake), 1);
            settle();
            check_sel("R3 single line", i + 1);
            do_cmd(5, i, 0);
            settle();
            check_sel("R9 single clear", 0);
        end

        // R1 urgency sweep with ties
        for (int i = 0; i < 32; i++) begin
            prio_m[i] = (i * 7) % 16;
            do_cmd(1, i, prio_m[i]);
        end
        for (int i = 0; i < 32; i++) do_cmd(4, i, 0);
        pend_m = '1;
        for (int k = 0; k < 32; k++) begin
            int w;
            settle();
            w = winner();
            check_sel("R1 winner", w);
            do_cmd(5, w - 1, 0);
            pend_m[w-1] = 1'b0;
        end
        settle();
        check_sel("R1 drained", 0);

        // R5/R6 lock behaviour
        do_cmd(6, 0, 1);
        pulse_hw(4);
        check("R6 locked hw no wake", int'(cpu_wake), 0);
        settle();
        check_sel("R5 locked hidden", 0);
        hard_wake = 1'b1;
        @(negedge clk);
        hard_wake = 1'b0;
        check("R6 hard wake", int'(cpu_wake), 1);
        do_cmd(6, 0, 0);
        check("R5 unlock wake", int'(cpu_wake), 1);
        settle();
        check_sel("R5 recorded while locked", 5);
        do_cmd(5, 4, 0);

        // R4 pre-mask
        do_cmd(3, 3, 0);
        pulse_hw(3);
        check("R6 masked hw wakes", int'(cpu_wake), 1);
        settle();
        check_sel("R4 masked not offered", 0);
        do_cmd(2, 3, 0);
        settle();
        check_sel("R4 enable pends", 4);
        do_cmd(5, 3, 0);

        // R9 clear-all variants
        do_cmd(3, 5, 0);
        pulse_hw(5);
        do_cmd(4, 6, 0);
        do_cmd(7, 0, 0);
        settle();
        check_sel("R9 clear enabled", 0);
        do_cmd(2, 5, 0);
        settle();
        check_sel("R9 masked premask kept", 6);
        do_cmd(5, 5, 0);
        do_cmd(3, 5, 0);
        pulse_hw(5);
        do_cmd(7, 0, 1);
        do_cmd(2, 5, 0);
        settle();
        check_sel("R9 clear all", 0);

        // R7/R8/R10 nesting
        do_cmd(1, 10, 50);
        do_cmd(1, 11, 20);
        do_cmd(1, 12, 50);
        do_cmd(4, 10, 0);
        settle();
        check_sel("R7 offer 10", 11);
        pulse_ack();
        check("R7 blocked after ack", int'(sel_valid), 0);
        settle();
        check_sel("R7 pending cleared", 0);
        do_cmd(4, 12, 0);
        check("R10 no wake equal level", int'(cpu_wake), 0);
        settle();
        check_sel("R3 equal not preempt", 0);
        do_cmd(4, 11, 0);
        check("R10 preempt wake", int'(cpu_wake), 1);
        settle();
        check_sel("R3 more urgent", 12);
        pulse_ack();
        settle();
        check_sel("R7 nested level 20", 0);
        pulse_eoi();
        settle();
        check_sel("R8 back to 50", 0);
        pulse_eoi();
        settle();
        check_sel("R8 back to idle", 13);
        do_cmd(5, 12, 0);
        pulse_eoi();
        do_cmd(1, 20, 255);
        do_cmd(4, 20, 0);
        settle();
        check_sel("R8 eoi idle ignored", 21);
        do_cmd(5, 20, 0);

        // R11 overflow
        for (int k = 0; k < 9; k++) do_cmd(1, k, 200 - 20 * k);
        for (int k = 0; k < 9; k++) begin
            do_cmd(4, k, 0);
            settle();
            check_sel("R11 offer nested", k + 1);
            pulse_ack();
            check("R11 stack_err", int'(stack_err), k == 8 ? 1 : 0);
            settle();
        end
        check_sel("R11 ignored ack keeps pending", 9);
        for (int k = 0; k < 8; k++) pulse_eoi();
        settle();
        check_sel("R11 unwound", 9);
        check("R11 sticky", int'(stack_err), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule